// File: doc/BRIEF.md
# Display Write FIFO Drain

This block is a short ring-buffer queue that holds pending writes from a CPU or DMA producer of a tile-based video display processor. Each queued write is stamped with the cycle at which it becomes eligible for commit. The stamp is the current cycle plus a fixed latency. That latency is scaled by 16 in the wide display mode and by 20 in the narrow mode. When the scheduler signals an external access slot and the oldest entry is due, the block commits that entry to its target memory through one of three registered write ports. The targets are a byte-addressed video RAM, a colour RAM and a vertical-scroll RAM.

Video RAM writes are byte commits. A whole-word write takes two slots: the high byte goes to the given address, then the low byte goes to the address with bit 0 flipped. A partial write takes one slot and stores a single byte at the flipped address. Colour RAM and scroll RAM take 16-bit words at an index derived from the address. A scroll RAM write whose index falls outside the populated range is discarded, but its entry still retires. The memories live outside the block and are written through the ports.

Top module: `disp_write_fifo`

## Requirements
- R1: While reset is held and on the cycle after it, `fifo_empty` is 1, `fifo_full` is 0 and no write strobe is asserted.
- R2: An entry enqueued on clock edge E commits on the first slot strobe sampled on an edge at or after E + LATENCY*16 when `wide_mode` was 1 at enqueue, or E + LATENCY*20 when it was 0. The write strobe is visible after that edge.
- R3: At most one write strobe is asserted per cycle, and a write strobe only follows an edge on which `slot_strobe` was 1.
- R4: Entries commit in enqueue order. `fifo_full` rises after DEPTH accepted entries. An enqueue presented while `fifo_full` is 1 is discarded and never commits.
- R5: When the last queued entry retires, `fifo_empty` returns to 1.
- R6: A video RAM entry (target 0) with partial code 1 writes the value's low byte to the address XOR 1 in one slot and then retires.
- R7: A video RAM entry with partial code 2 writes the value's high byte to the address XOR 1 in one slot and then retires.
- R8: A video RAM entry with partial code 0 writes the high byte to the unmodified address in one slot, then the low byte to the address XOR 1 in the next due slot, then retires. A younger entry waits behind it.
- R9: A colour RAM entry (target 1) writes the full 16-bit value at index (address >> 1) modulo CRAM_WORDS.
- R10: A scroll RAM entry (target 2) computes index (address >> 1) AND 63. It writes the 16-bit value when that index is below VSRAM_WORDS; otherwise it produces no write strobe and still retires.
- R11: An entry with target code 3 retires on its due slot without asserting any write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 selects the x16 latency scale, 0 the x20 scale; sampled at enqueue |
| enq_valid | input | 1 | Enqueue request |
| enq_addr | input | ADDR_W | Destination address |
| enq_data | input | DATA_W | 16-bit value to write |
| enq_target | input | 2 | 0 video RAM, 1 colour RAM, 2 scroll RAM, 3 none |
| enq_partial | input | 2 | 0 whole word, 1 low byte, 2 high byte (video RAM only) |
| slot_strobe | input | 1 | External access slot available this cycle |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| fifo_empty | output | 1 | Queue holds no entries |
| vram_we | output | 1 | Video RAM byte write strobe |
| vram_addr | output | ADDR_W | Video RAM byte address |
| vram_byte | output | DATA_W/2 | Video RAM byte data |
| cram_we | output | 1 | Colour RAM write strobe |
| cram_idx | output | log2(CRAM_WORDS) | Colour RAM word index |
| cram_word | output | DATA_W | Colour RAM data |
| vsram_we | output | 1 | Scroll RAM write strobe |
| vsram_idx | output | log2(VSRAM_WORDS) | Scroll RAM word index |
| vsram_word | output | DATA_W | Scroll RAM data |

## Verification
The bench uses the default build: DEPTH 4, LATENCY 3 (48 or 60 cycles), CRAM_WORDS 64, VSRAM_WORDS 40 within a 64-entry span. With a depth of four, the full, overflow and wrap conditions are reached after a handful of enqueues. With a 64-entry scroll span, every scroll index, including all 24 that must be dropped, is swept exhaustively. Latency is measured edge-exact in both modes from several start phases. The three video RAM partial codes are each applied to odd, even and extreme addresses. The colour RAM index fold is swept across a thousand addresses.

// File: rtl/disp_wfifo_pkg.sv
package disp_wfifo_pkg;

  typedef enum logic [1:0] {
    TGT_VRAM  = 2'd0,
    TGT_CRAM  = 2'd1,
    TGT_VSRAM = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;

  localparam logic [1:0] PART_WORD = 2'd0;

endpackage

// File: rtl/dwf_timer.sv
module dwf_timer #(
  parameter int CYC_W       = 16,
  parameter int LATENCY     = 3,
  parameter int WIDE_STEP   = 16,
  parameter int NARROW_STEP = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wide,
  output logic [CYC_W-1:0] now,
  output logic [CYC_W-1:0] ready_at
);
  localparam logic [CYC_W-1:0] DLY_WIDE   = CYC_W'(LATENCY * WIDE_STEP);
  localparam logic [CYC_W-1:0] DLY_NARROW = CYC_W'(LATENCY * NARROW_STEP);

  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + CYC_W'(1);
  end

  assign ready_at = now + (wide ? DLY_WIDE : DLY_NARROW);
endmodule

// File: rtl/dwf_ring.sv
module dwf_ring
  import disp_wfifo_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CYC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [CYC_W-1:0]  in_rdy,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  tgt_e              in_tgt,
  input  logic [1:0]        in_part,
  input  logic              pop,
  output logic [CYC_W-1:0]  head_rdy,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output tgt_e              head_tgt,
  output logic [1:0]        head_part,
  output logic              full,
  output logic              empty
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CYC_W-1:0]  m_rdy  [DEPTH];
  logic [ADDR_W-1:0] m_addr [DEPTH];
  logic [DATA_W-1:0] m_data [DEPTH];
  tgt_e              m_tgt  [DEPTH];
  logic [1:0]        m_part [DEPTH];

  logic [IDX_W-1:0] wr_q, rd_q, rd_next;
  logic             empty_q, accept;

  assign full    = (wr_q == rd_q) && !empty_q;
  assign empty   = empty_q;
  assign accept  = push && !full;
  assign rd_next = rd_q + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (accept) begin
      m_rdy[wr_q]  <= in_rdy;
      m_addr[wr_q] <= in_addr;
      m_data[wr_q] <= in_data;
      m_tgt[wr_q]  <= in_tgt;
      m_part[wr_q] <= in_part;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= '0;
      rd_q    <= '0;
      empty_q <= 1'b1;
    end else begin
      if (accept) wr_q <= wr_q + IDX_W'(1);
      if (accept && empty_q)  rd_q <= wr_q;
      else if (pop)           rd_q <= rd_next;
      if (accept)                         empty_q <= 1'b0;
      else if (pop && (rd_next == wr_q))  empty_q <= 1'b1;
    end
  end

  assign head_rdy  = m_rdy[rd_q];
  assign head_addr = m_addr[rd_q];
  assign head_data = m_data[rd_q];
  assign head_tgt  = m_tgt[rd_q];
  assign head_part = m_part[rd_q];
endmodule

// File: rtl/dwf_commit.sv
module dwf_commit
  import disp_wfifo_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int CYC_W       = 16,
  parameter int CRAM_WORDS  = 64,
  parameter int VSRAM_WORDS = 40,
  parameter int VSRAM_SPAN  = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           slot,
  input  logic [CYC_W-1:0]               now,
  input  logic                           empty,
  input  logic [CYC_W-1:0]               head_rdy,
  input  logic [ADDR_W-1:0]              head_addr,
  input  logic [DATA_W-1:0]              head_data,
  input  tgt_e                           head_tgt,
  input  logic [1:0]                     head_part,
  output logic                           pop,
  output logic                           vram_we,
  output logic [ADDR_W-1:0]              vram_addr,
  output logic [DATA_W/2-1:0]            vram_byte,
  output logic                           cram_we,
  output logic [$clog2(CRAM_WORDS)-1:0]  cram_idx,
  output logic [DATA_W-1:0]              cram_word,
  output logic                           vsram_we,
  output logic [$clog2(VSRAM_WORDS)-1:0] vsram_idx,
  output logic [DATA_W-1:0]              vsram_word
);
  localparam int BYTE_W  = DATA_W / 2;
  localparam int CRAM_AW = $clog2(CRAM_WORDS);
  localparam int SPAN_AW = $clog2(VSRAM_SPAN);
  localparam int VS_AW   = $clog2(VSRAM_WORDS);
  localparam logic [SPAN_AW:0] VS_LIMIT = (SPAN_AW + 1)'(VSRAM_WORDS);

  logic signed [CYC_W-1:0] elapsed;
  logic                    due, hi_q, whole, vs_ok;
  logic [SPAN_AW-1:0]      vs_sel;
  logic [BYTE_W-1:0]       hi_byte, lo_byte;

  assign elapsed = $signed(now - head_rdy);
  assign due     = slot && !empty && (elapsed >= 0);
  assign whole   = (head_part == PART_WORD);
  assign vs_sel  = head_addr[SPAN_AW:1];
  assign vs_ok   = {1'b0, vs_sel} < VS_LIMIT;
  assign hi_byte = head_data[DATA_W-1:BYTE_W];
  assign lo_byte = head_data[BYTE_W-1:0];
  assign pop     = due && !((head_tgt == TGT_VRAM) && whole && !hi_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      vram_we  <= 1'b0;
      cram_we  <= 1'b0;
      vsram_we <= 1'b0;
      hi_q     <= 1'b0;
    end else begin
      vram_we  <= 1'b0;
      cram_we  <= 1'b0;
      vsram_we <= 1'b0;
      if (due) begin
        unique case (head_tgt)
          TGT_VRAM: begin
            vram_we <= 1'b1;
            if (whole && !hi_q) begin
              vram_addr <= head_addr;
              vram_byte <= hi_byte;
              hi_q      <= 1'b1;
            end else begin
              vram_addr <= head_addr ^ ADDR_W'(1);
              vram_byte <= (whole || !head_part[1]) ? lo_byte : hi_byte;
              hi_q      <= 1'b0;
            end
          end
          TGT_CRAM: begin
            cram_we   <= 1'b1;
            cram_idx  <= head_addr[CRAM_AW:1];
            cram_word <= head_data;
          end
          TGT_VSRAM: begin
            vsram_we   <= vs_ok;
            vsram_idx  <= vs_sel[VS_AW-1:0];
            vsram_word <= head_data;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/disp_write_fifo.sv
module disp_write_fifo
  import disp_wfifo_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int CYC_W       = 16,
  parameter int LATENCY     = 3,
  parameter int CRAM_WORDS  = 64,
  parameter int VSRAM_WORDS = 40,
  parameter int VSRAM_SPAN  = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wide_mode,
  input  logic                           enq_valid,
  input  logic [ADDR_W-1:0]              enq_addr,
  input  logic [DATA_W-1:0]              enq_data,
  input  logic [1:0]                     enq_target,
  input  logic [1:0]                     enq_partial,
  input  logic                           slot_strobe,
  output logic                           fifo_full,
  output logic                           fifo_empty,
  output logic                           vram_we,
  output logic [ADDR_W-1:0]              vram_addr,
  output logic [DATA_W/2-1:0]            vram_byte,
  output logic                           cram_we,
  output logic [$clog2(CRAM_WORDS)-1:0]  cram_idx,
  output logic [DATA_W-1:0]              cram_word,
  output logic                           vsram_we,
  output logic [$clog2(VSRAM_WORDS)-1:0] vsram_idx,
  output logic [DATA_W-1:0]              vsram_word
);
  logic [CYC_W-1:0]  now, ready_at, head_rdy;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data;
  tgt_e              head_tgt;
  logic [1:0]        head_part;
  logic              retire;

  dwf_timer #(.CYC_W(CYC_W), .LATENCY(LATENCY)) u_tm (
    .clk(clk), .rst(rst), .wide(wide_mode), .now(now), .ready_at(ready_at)
  );

  dwf_ring #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_W(CYC_W)) u_rg (
    .clk(clk), .rst(rst), .push(enq_valid),
    .in_rdy(ready_at), .in_addr(enq_addr), .in_data(enq_data),
    .in_tgt(tgt_e'(enq_target)), .in_part(enq_partial),
    .pop(retire),
    .head_rdy(head_rdy), .head_addr(head_addr), .head_data(head_data),
    .head_tgt(head_tgt), .head_part(head_part),
    .full(fifo_full), .empty(fifo_empty)
  );

  dwf_commit #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_W(CYC_W),
    .CRAM_WORDS(CRAM_WORDS), .VSRAM_WORDS(VSRAM_WORDS), .VSRAM_SPAN(VSRAM_SPAN)
  ) u_cm (
    .clk(clk), .rst(rst), .slot(slot_strobe), .now(now), .empty(fifo_empty),
    .head_rdy(head_rdy), .head_addr(head_addr), .head_data(head_data),
    .head_tgt(head_tgt), .head_part(head_part), .pop(retire),
    .vram_we(vram_we), .vram_addr(vram_addr), .vram_byte(vram_byte),
    .cram_we(cram_we), .cram_idx(cram_idx), .cram_word(cram_word),
    .vsram_we(vsram_we), .vsram_idx(vsram_idx), .vsram_word(vsram_word)
  );
endmodule

// File: rtl/disp_write_fifo_chk.sv
module disp_write_fifo_chk #(
  parameter int VSRAM_WORDS = 40
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           slot_strobe,
  input logic                           enq_valid,
  input logic                           fifo_full,
  input logic                           fifo_empty,
  input logic                           retire,
  input logic                           vram_we,
  input logic                           cram_we,
  input logic                           vsram_we,
  input logic [$clog2(VSRAM_WORDS)-1:0] vsram_idx
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (fifo_empty && !fifo_full && !vram_we && !cram_we && !vsram_we));

  assert_strobe_needs_slot_R3: assert property (@(posedge clk) disable iff (rst)
    (vram_we || cram_we || vsram_we) |-> $past(slot_strobe));

  assert_single_write_R3: assert property (@(posedge clk) disable iff (rst)
    $countones({vram_we, cram_we, vsram_we}) <= 1);

  assert_full_excl_empty_R4: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty));

  assert_full_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !retire) |=> fifo_full);

  assert_no_retire_empty_R5: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |-> !retire);

  assert_enq_fills_R5: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty && enq_valid) |=> !fifo_empty);

  assert_vsram_in_range_R10: assert property (@(posedge clk) disable iff (rst)
    vsram_we |-> (int'(vsram_idx) < VSRAM_WORDS));
endmodule

bind disp_write_fifo disp_write_fifo_chk #(.VSRAM_WORDS(VSRAM_WORDS)) u_chk (
  .clk(clk), .rst(rst), .slot_strobe(slot_strobe), .enq_valid(enq_valid),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty), .retire(retire),
  .vram_we(vram_we), .cram_we(cram_we), .vsram_we(vsram_we), .vsram_idx(vsram_idx)
);

// File: tb/sim_disp_write_fifo.sv
`timescale 1ns/1ps
module sim_disp_write_fifo;
  localparam int LAT = 3;
  localparam int LW  = LAT * 16;
  localparam int LN  = LAT * 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_mode = 1'b1, enq_valid = 1'b0, slot_strobe = 1'b0;
  logic [15:0] enq_addr = '0, enq_data = '0;
  logic [1:0]  enq_target = '0, enq_partial = '0;
  logic        fifo_full, fifo_empty, vram_we, cram_we, vsram_we;
  logic [15:0] vram_addr, cram_word, vsram_word;
  logic [7:0]  vram_byte;
  logic [5:0]  cram_idx, vsram_idx;

  int tests = 0, fails = 0, ecount = 0;
  int lk[64], la[64], ld[64], le[64];
  int log_n = 0;

  always #2.5 clk = ~clk;

  disp_write_fifo u0 (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .enq_valid(enq_valid),
    .enq_addr(enq_addr), .enq_data(enq_data), .enq_target(enq_target),
    .enq_partial(enq_partial), .slot_strobe(slot_strobe),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .vram_we(vram_we), .vram_addr(vram_addr), .vram_byte(vram_byte),
    .cram_we(cram_we), .cram_idx(cram_idx), .cram_word(cram_word),
    .vsram_we(vsram_we), .vsram_idx(vsram_idx), .vsram_word(vsram_word)
  );

  always @(posedge clk) ecount <= ecount + 1;

  always @(negedge clk) begin
    if (!rst && (vram_we || cram_we || vsram_we) && log_n < 64) begin
      lk[log_n] = vram_we ? 1 : (cram_we ? 2 : 3);
      la[log_n] = vram_we ? int'(vram_addr) : (cram_we ? int'(cram_idx) : int'(vsram_idx));
      ld[log_n] = vram_we ? int'(vram_byte) : (cram_we ? int'(cram_word) : int'(vsram_word));
      le[log_n] = ecount;
      log_n = log_n + 1;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (ecount > 150000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<=150000", ecount);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic enq(input int a, input int d, input int t, input int p, input bit w,
                     output int e);
    enq_addr = 16'(a); enq_data = 16'(d); enq_target = 2'(t); enq_partial = 2'(p);
    wide_mode = w; enq_valid = 1'b1;
    @(negedge clk);
    e = ecount;
    enq_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int e, e2, idx, a, d;
    repeat (3) @(negedge clk);
    chk(fifo_empty == 1'b1, "R1 empty during reset", fifo_empty, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(fifo_empty && !fifo_full, "R1 empty/full after reset", {fifo_full, fifo_empty}, 1);
    chk(!(vram_we || cram_we || vsram_we), "R1 no strobe", {vram_we, cram_we, vsram_we}, 0);

    // R2: latency from several start phases, both modes
    foreach (le[i]) le[i] = 0;
    for (int w = 0; w < 2; w++) begin
      for (int g = 0; g < 4; g++) begin
        slot_strobe = 1'b1;
        idle(g * 5 + 1);
        log_n = 0;
        enq(2 * g, 16'h1000 + g, 1, 0, w[0], e);
        idle(80);
        chk(log_n == 1, "R2 single commit", log_n, 1);
        chk(le[0] == e + (w ? LW : LN), "R2 commit edge", le[0] - e, w ? LW : LN);
      end
    end

    // R3: no commit without slot; one commit per strobe
    slot_strobe = 1'b0;
    log_n = 0;
    enq(8, 16'hBEEF, 1, 0, 1'b1, e);
    idle(100);
    chk(log_n == 0, "R3 no slot no write", log_n, 0);
    chk(!fifo_empty, "R3 entry still queued", fifo_empty, 0);
    slot_strobe = 1'b1;
    @(negedge clk);
    slot_strobe = 1'b0;
    idle(4);
    chk(log_n == 1 && lk[0] == 2 && ld[0] == 16'hBEEF, "R3 one write per strobe", log_n, 1);
    chk(fifo_empty, "R5 empty after retire", fifo_empty, 1);

    // R6/R7/R8: video RAM partial codes over several addresses
    slot_strobe = 1'b1;
    for (int k = 0; k < 5; k++) begin
      a = (k == 0) ? 16'h0000 : (k == 1) ? 16'h1235 : (k == 2) ? 16'hFFFE :
          (k == 3) ? 16'h8001 : 16'h4AAA;
      d = a ^ 16'hA5C3;
      for (int p = 0; p < 3; p++) begin
        log_n = 0;
        enq(a, d, 0, p, 1'b1, e);
        idle(LW + 8);
        if (p == 0) begin
          chk(log_n == 2, "R8 two byte commits", log_n, 2);
          chk(la[0] == a && ld[0] == (d >> 8) && le[0] == e + LW, "R8 high byte first",
              la[0], a);
          chk(la[1] == (a ^ 1) && ld[1] == (d & 255) && le[1] == e + LW + 1,
              "R8 low byte next slot", la[1], a ^ 1);
        end else if (p == 1) begin
          chk(log_n == 1 && lk[0] == 1, "R6 one write", log_n, 1);
          chk(la[0] == (a ^ 1) && ld[0] == (d & 255), "R6 low byte at addr^1", ld[0], d & 255);
        end else begin
          chk(log_n == 1 && lk[0] == 1, "R7 one write", log_n, 1);
          chk(la[0] == (a ^ 1) && ld[0] == (d >> 8), "R7 high byte at addr^1", ld[0], d >> 8);
        end
        chk(fifo_empty, "R5 empty after vram entry", fifo_empty, 1);
      end
    end

    // R8: younger entry waits behind a split write
    log_n = 0;
    enq(16'h0200, 16'h1234, 0, 0, 1'b1, e);
    enq(16'h0006, 16'h5678, 1, 0, 1'b1, e2);
    idle(LW + 8);
    chk(log_n == 3, "R8 three commits", log_n, 3);
    chk(lk[2] == 2 && le[2] == e + LW + 2 && la[2] == 3, "R8 younger waits", le[2] - e, LW + 2);

    // R9: colour RAM index fold sweep
    for (int s = 0; s < 1024; s += 13) begin
      log_n = 0;
      d = (s * 37) & 16'hFFFF;
      enq(s, d, 1, 0, 1'b1, e);
      idle(LW + 4);
      chk(log_n == 1 && lk[0] == 2 && la[0] == ((s >> 1) & 63) && ld[0] == d,
          "R9 colour index/data", la[0], (s >> 1) & 63);
    end

    // R10: exhaustive scroll index sweep with range drop
    for (int i = 0; i < 64; i++) begin
      log_n = 0;
      a = ((i * 3) << 7) | (i << 1) | (i & 1);
      enq(a, 16'h4000 + i, 2, 0, 1'b1, e);
      idle(LW + 4);
      if (i < 40)
        chk(log_n == 1 && lk[0] == 3 && la[0] == i && ld[0] == 16'h4000 + i,
            "R10 scroll write", la[0], i);
      else
        chk(log_n == 0, "R10 out of range dropped", log_n, 0);
      chk(fifo_empty, "R10 entry retired", fifo_empty, 1);
    end

    // R11: target 3 retires silently
    log_n = 0;
    enq(16'h0042, 16'h7777, 3, 0, 1'b0, e);
    idle(LN + 4);
    chk(log_n == 0, "R11 no write", log_n, 0);
    chk(fifo_empty, "R11 retired", fifo_empty, 1);

    // R4/R5: fill, overflow discard, ordered drain
    slot_strobe = 1'b0;
    log_n = 0;
    for (int i = 0; i < 4; i++) begin
      chk(!fifo_full, "R4 not full before depth", fifo_full, 0);
      enq((10 + i) * 2, 100 + i, 1, 0, 1'b1, e);
    end
    chk(fifo_full, "R4 full at depth", fifo_full, 1);
    enq(40, 999, 1, 0, 1'b1, e);
    chk(fifo_full, "R4 still full", fifo_full, 1);
    slot_strobe = 1'b1;
    idle(LW + 10);
    chk(log_n == 4, "R4 only accepted entries commit", log_n, 4);
    for (int i = 0; i < 4; i++)
      chk(la[i] == 10 + i && ld[i] == 100 + i, "R4 commit order", la[i], 10 + i);
    chk(fifo_empty && !fifo_full, "R5 empty after drain", fifo_empty, 1);

    summary();
  end
endmodule